// File: doc/BRIEF.md
# Serial NRZI Decoder with Self-Synchronizing Descrambler

This block takes the reclocked line bit stream of a serial video receiver and returns the original data, one bit per serial clock. The stream first passes a transition decoder (NRZI to NRZ). A feed-forward descrambler for x^9 + x^4 + 1 follows it. Together the two stages multiply the received sequence modulo 2 by (x^9 + x^4 + 1)(x + 1). The result goes out serially, at the full bit rate, to a sync-word detector further down the chain.

A strobe qualifies each input bit. Cycles without the strobe leave all state untouched. The descrambler has no feedback, so it locks on by itself. Once the stream has filled its history, the output is correct whatever the registers held before. The output strobe stays low until then.

Top module: `nrzi_descrambler`

## Requirements
- R1: While rst_ni is low, data_o and data_valid_o are 0. Reset clears the previous-bit register and the whole delay line to 0.
- R2: The transition stage produces 1 when an accepted line bit differs from the previous accepted line bit, and 0 otherwise. Right after reset the previous bit counts as 0. As a result, the first four outputs after reset equal line_k XOR line_(k-1), with line_0 = 0.
- R3: Each output bit is n_k XOR n_(k-4) XOR n_(k-9), where n is the transition-decoded sequence. The output therefore reproduces the source data of a matching scrambler: y = x XOR y delayed 4 XOR y delayed 9, followed by NRZI.
- R4: data_o and data_valid_o change at the clock edge that accepts an input bit (valid_i high), so they appear one cycle after the bit is presented. data_valid_o is high only in a cycle that follows an accepted bit.
- R5: After reset, the outputs for the first 10 accepted bits carry data_valid_o = 0. The 11th accepted bit and every later one carry data_valid_o = 1.
- R6: A cycle with valid_i low changes no state. After such a cycle data_o holds its value and data_valid_o is 0. The decoded stream continues correctly across any gap.
- R7: Once valid, the output is correct for any initial state of the far-end scrambler.
- R8: A reset in the middle of a stream restarts the 10-bit warm-up. After it, the stream is again recovered exactly from the 11th accepted bit on.
- R9: The recovery holds for pathological source data: long runs of zeros and ones, and alternating 0x300/0x198 and 0x200/0x110 ten-bit words sent LSB first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Qualifies line_bit_i in this cycle |
| line_bit_i | input | 1 | Reclocked received line bit |
| data_o | output | 1 | Descrambled data bit |
| data_valid_o | output | 1 | data_o carries a new, settled bit |

## Verification
The bench scrambles known data through an independent NRZI scrambler model whose starting state is random. It then checks every bit from the 11th on. A tap at the wrong delay or a missing transition stage would corrupt almost every bit. The warm-up boundary is probed exactly at bits 10 and 11, so an off-by-one counter would assert the strobe one bit early or one bit late. Idle gaps check that a design advancing without the strobe either loses stream alignment or lets data_o move. Directed line bits straight after reset expose registers that are not cleared, and a mid-stream reset shows whether the warm-up restarts.

// File: rtl/nrzi_dscr_pkg.sv
package nrzi_dscr_pkg;
  typedef struct packed {
    logic valid;
    logic data;
  } beat_t;
endpackage

// File: rtl/nrzi_to_nrz.sv
module nrzi_to_nrz
  import nrzi_dscr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  beat_t line_i,
  output beat_t nrz_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           prev_q <= 1'b0;
    else if (line_i.valid) prev_q <= line_i.data;
  end

  always_comb begin
    nrz_o.valid = line_i.valid;
    nrz_o.data  = line_i.data ^ prev_q;
  end
endmodule

// File: rtl/ff_descrambler.sv
module ff_descrambler
  import nrzi_dscr_pkg::*;
#(
  parameter int NEAR_TAP = 4,
  parameter int FAR_TAP  = 9
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  beat_t nrz_i,
  output logic  data_o
);
  localparam int DEPTH = FAR_TAP;

  // hist_q[i] holds the NRZ bit delayed by i+1 accepted bits
  logic [DEPTH-1:0] hist_q;
  logic             out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      out_q  <= 1'b0;
    end else if (nrz_i.valid) begin
      hist_q <= {hist_q[DEPTH-2:0], nrz_i.data};
      out_q  <= nrz_i.data ^ hist_q[NEAR_TAP-1] ^ hist_q[FAR_TAP-1];
    end
  end

  assign data_o = out_q;
endmodule

// File: rtl/warmup_gate.sv
module warmup_gate #(
  parameter int WARM_N = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  output logic valid_o
);
  localparam int            CW     = $clog2(WARM_N + 1);
  localparam logic [CW-1:0] WARM_C = CW'(WARM_N);

  logic [CW-1:0] cnt_q;
  logic          warm;
  logic          valid_q;

  assign warm = (cnt_q == WARM_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (valid_i && !warm) cnt_q <= cnt_q + 1'b1;
      valid_q <= valid_i && warm;
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/nrzi_descrambler.sv
module nrzi_descrambler
  import nrzi_dscr_pkg::*;
#(
  parameter int NEAR_TAP = 4,
  parameter int FAR_TAP  = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic line_bit_i,
  output logic data_o,
  output logic data_valid_o
);
  // one bit for the transition stage plus the full delay line
  localparam int WARM_N = FAR_TAP + 1;

  beat_t line_beat;
  beat_t nrz_beat;

  assign line_beat.valid = valid_i;
  assign line_beat.data  = line_bit_i;

  nrzi_to_nrz u_nrzi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_beat),
    .nrz_o  (nrz_beat)
  );

  ff_descrambler #(
    .NEAR_TAP (NEAR_TAP),
    .FAR_TAP  (FAR_TAP)
  ) u_dscr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .nrz_i  (nrz_beat),
    .data_o (data_o)
  );

  warmup_gate #(
    .WARM_N (WARM_N)
  ) u_warm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .valid_o (data_valid_o)
  );
endmodule

// File: rtl/nrzi_descrambler_chk.sv
module nrzi_descrambler_chk #(
  parameter int WARM_N = 10
) (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic data_o,
  input logic data_valid_o
);
  localparam int            CW    = $clog2(WARM_N + 2);
  localparam logic [CW-1:0] SAT_C = CW'(WARM_N + 1);

  logic [CW-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          seen_q <= '0;
    else if (valid_i && seen_q != SAT_C)  seen_q <= seen_q + 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_CLEAR: assert (!data_valid_o && !data_o); // R1
  end

  AST_VALID_FOLLOWS_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> $past(valid_i)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!data_valid_o && $stable(data_o))); // R6

  AST_NO_EARLY_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> (seen_q == SAT_C)); // R5

  AST_VALID_AFTER_WARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(valid_i) && seen_q == SAT_C && $past(seen_q) == SAT_C) |-> data_valid_o); // R5
endmodule

bind nrzi_descrambler nrzi_descrambler_chk #(.WARM_N(FAR_TAP + 1)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .data_o       (data_o),
  .data_valid_o (data_valid_o)
);

// File: tb/nrzi_descrambler_test.sv
`timescale 1ns/1ps
module nrzi_descrambler_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic line_bit_i = 1'b0;
  logic data_o;
  logic data_valid_o;

  int checks = 0;
  int errors = 0;
  int acc = 0;
  bit done = 0;

  // far-end scrambler model
  logic [8:0] s_hist;
  logic       s_line;

  // [9:0] word sent LSB first, [11:10] idle cycles after it
  localparam logic [11:0] VEC [16] = '{
    {2'd0, 10'h300}, {2'd0, 10'h198}, {2'd0, 10'h300}, {2'd1, 10'h198},
    {2'd0, 10'h200}, {2'd0, 10'h110}, {2'd0, 10'h200}, {2'd2, 10'h110},
    {2'd0, 10'h3FF}, {2'd0, 10'h000}, {2'd0, 10'h000}, {2'd3, 10'h000},
    {2'd0, 10'h3FF}, {2'd0, 10'h3FF}, {2'd1, 10'h2A5}, {2'd0, 10'h15A}
  };

  always #5 clk_i = ~clk_i;

  nrzi_descrambler uut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid_i),
    .line_bit_i   (line_bit_i),
    .data_o       (data_o),
    .data_valid_o (data_valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic scramble(input logic d);
    logic s;
    s      = d ^ s_hist[3] ^ s_hist[8];
    s_hist = {s_hist[7:0], s};
    s_line = s_line ^ s;
    return s_line;
  endfunction

  task automatic step(input logic v, input logic b);
    valid_i    = v;
    line_bit_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(data_o == 1'b0, "R1 data_o in reset", data_o, 0);
    chk(data_valid_o == 1'b0, "R1 data_valid_o in reset", data_valid_o, 0);
    rst_ni = 1'b1;
    acc = 0;
  endtask

  task automatic send_data(input logic d, input string req);
    acc++;
    step(1'b1, scramble(d));
    if (acc >= 11) begin
      chk(data_valid_o == 1'b1, {req, " valid"}, data_valid_o, 1);
      chk(data_o == d, {req, " data"}, data_o, d);
    end else begin
      chk(data_valid_o == 1'b0, "R5 warm-up valid low", data_valid_o, 0);
    end
  endtask

  task automatic idle();
    logic prev;
    prev = data_o;
    step(1'b0, 1'($urandom));
    chk(data_valid_o == 1'b0, "R6 idle valid low", data_valid_o, 0);
    chk(data_o == prev, "R6 idle data held", data_o, prev);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    s_hist = 9'($urandom) | 9'h001;
    s_line = 1'b1;
    @(negedge clk_i);
    do_reset();

    // R2: raw line bits straight after reset, taps still clear
    begin
      logic [3:0] raw;
      logic       prev_l;
      raw    = 4'b1011;
      prev_l = 1'b0;
      for (int i = 0; i < 4; i++) begin
        step(1'b1, raw[i]);
        chk(data_o == (raw[i] ^ prev_l), "R2 transition decode", data_o, raw[i] ^ prev_l);
        prev_l = raw[i];
      end
    end

    do_reset();
    // R5 boundary and R7 random scrambler start
    for (int i = 0; i < 10; i++) send_data(1'($urandom), "R7");
    send_data(1'b1, "R5 eleventh bit");
    for (int i = 0; i < 20; i++) send_data(1'($urandom), "R7");

    // R9/R6: table walk with idle gaps
    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < 16; i++) begin
        for (int b = 0; b < 10; b++) send_data(VEC[i][b], "R9");
        for (int g = 0; g < int'(VEC[i][11:10]); g++) idle();
      end
    end

    // R9: long runs
    for (int i = 0; i < 300; i++) send_data(1'b0, "R9 zero run");
    for (int i = 0; i < 300; i++) send_data(1'b1, "R9 one run");

    // R3: long random stream with sparse gaps
    for (int i = 0; i < 3000; i++) begin
      send_data(1'($urandom), "R3");
      if ($urandom_range(0, 15) == 0) idle();
    end

    // R8: reset mid-stream, scrambler keeps running
    do_reset();
    for (int i = 0; i < 9; i++) send_data(1'($urandom), "R8");
    send_data(1'b0, "R8");
    chk(data_valid_o == 1'b0, "R8 tenth bit still invalid", data_valid_o, 0);
    send_data(1'b1, "R8 eleventh bit");
    for (int i = 0; i < 200; i++) send_data(1'($urandom), "R8");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule